// File: doc/BRIEF.md
# Dual-Mode Pixel Time-Stamp Counter

This block is the digital back end of one imaging pixel. It runs in one of two modes and uses a single 6-bit counter for both. In timing mode it time-stamps the first photon of a frame. A coarse count of reference-clock periods runs from the detector START to the global STOP. A fine 4-bit phase of START is taken from a snapshot of 16 evenly shifted reference-clock replicas. A global 4-bit STOP phase code, which is asynchronous to the reference clock, corrects that fine phase. Because STOP falls at changing clock positions, errors in individual bins are spread across the scale. In counting mode the same counter counts detector pulses over a frame.

A frame opens with a frame-start strobe and closes with a frame-end strobe. At frame end the block loads a 10-bit result, a valid flag and an overflow flag into output registers. Those registers hold until the next frame end, so the array readout can scan them while the next frame is acquired. At the same edge the working state is cleared. With a 200 MHz reference the result LSB is about 312 ps and full scale is 320 ns. At 50 MHz the LSB is 1.25 ns and full scale is 1.28 µs.

Top module: `pixel_tdc_counter`

## Requirements
- R1: While reset is active, and until the first frame end after it, result, result_valid and overflow are all 0.
- R2: The mode is chosen by mode_count: 1 selects photon counting and 0 selects photon timing. The three outputs change only at the clock edge that registers frame_end, and hold their values at every other edge.
- R3: The START phase code is the smallest index i in 0..15 for which snap[i]=0 and snap[(i+15) mod 16]=1. If no index meets this, the code is 0. This rule resolves bubbles by taking the lowest transition.
- R4: In timing mode the coarse count is the number of clock edges after the START edge, up to and including the STOP edge. The frame result is coarse*16 + stop_phase - start_code. A negative value is clamped to 0. result_valid is 1 and overflow is 0.
- R5: Only the first START of a frame is timed. Any later START in the same frame has no effect. A STOP that arrives before any START has no effect, and neither does a STOP after the first accepted one.
- R6: When START and STOP arrive in the same cycle, the coarse count is 0.
- R7: If the coarse count would pass 63 before STOP arrives, the frame reports overflow=1, result_valid=0 and result=0.
- R8: A timing frame without both an accepted START and an accepted STOP reports result_valid=0, overflow=0 and result=0.
- R9: In counting mode each START pulse adds one. At frame end, result[5:0] holds the count, result[9:6] is 0 and result_valid is 1.
- R10: In counting mode the count saturates at 63. When a pulse arrives at 63, the frame reports overflow=1.
- R11: frame_start and frame_end both clear the working state. START and STOP pulses that arrive in a cycle carrying either strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_count | input | 1 | 1 = photon counting, 0 = photon timing |
| frame_start | input | 1 | Opens a frame; clears working state |
| frame_end | input | 1 | Closes a frame; loads outputs and clears working state |
| start_pulse | input | 1 | Detector START, one cycle per photon |
| stop_strobe | input | 1 | Global STOP, one cycle |
| snap | input | 16 | Multiphase clock snapshot taken at START |
| stop_phase | input | 4 | Global STOP phase code |
| result | output | 10 | Time word or photon count |
| result_valid | output | 1 | Result holds a measurement |
| overflow | output | 1 | Coarse wrap (timing) or count saturation (counting) |

## Verification
START and STOP can both arrive in the cycle that opens a measurement. The bench drives them together with fine codes on either side of each other, so the clamp at zero and a small positive difference are both reached. A correct result shows a coarse count of zero, and the borrow from the coarse field is judged against a computed expected word. Two further collisions are also driven: a START in the frame-end cycle, which must not be counted, and a second START in the same frame, which must leave the first time stamp unchanged.

// File: rtl/pixel_tdc_counter.sv
module pixel_tdc_counter #(
  parameter int CW     = 6,
  parameter int PHASES = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 mode_count,
  input  logic                                 frame_start,
  input  logic                                 frame_end,
  input  logic                                 start_pulse,
  input  logic                                 stop_strobe,
  input  logic [PHASES-1:0]                    snap,
  input  logic [$clog2(PHASES)-1:0]            stop_phase,
  output logic [CW+$clog2(PHASES)-1:0]         result,
  output logic                                 result_valid,
  output logic                                 overflow
);
  localparam int FW = $clog2(PHASES);
  localparam int RW = CW + FW;
  localparam int TW = RW + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;
  logic          hit, done, ovf_w;
  logic [FW-1:0] t_start, t_stop, snap_code;
  logic [TW-1:0] tw;
  logic [RW-1:0] t_time, next_res;
  logic          next_valid;
  logic          clear;

  always_comb begin
    snap_code = '0;
    for (int i = PHASES - 1; i >= 0; i--)
      if (!snap[i] && snap[(i + PHASES - 1) % PHASES]) snap_code = FW'(i);
  end

  assign clear      = frame_start | frame_end;
  assign tw         = {1'b0, cnt, {FW{1'b0}}} + TW'(t_stop) - TW'(t_start);
  assign t_time     = tw[RW] ? '0 : tw[RW-1:0];
  assign next_valid = mode_count | (hit & done & ~ovf_w);
  assign next_res   = mode_count ? RW'(cnt) : (next_valid ? t_time : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
      overflow     <= 1'b0;
    end else if (frame_end) begin
      result       <= next_res;
      result_valid <= next_valid;
      overflow     <= ovf_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      hit     <= 1'b0;
      done    <= 1'b0;
      ovf_w   <= 1'b0;
      t_start <= '0;
      t_stop  <= '0;
    end else if (clear) begin
      cnt     <= '0;
      hit     <= 1'b0;
      done    <= 1'b0;
      ovf_w   <= 1'b0;
      t_start <= '0;
      t_stop  <= '0;
    end else if (mode_count) begin
      if (start_pulse) begin
        if (cnt == CMAX) ovf_w <= 1'b1;
        else             cnt   <= cnt + 1'b1;
      end
    end else if (!hit) begin
      if (start_pulse) begin
        hit     <= 1'b1;
        cnt     <= '0;
        t_start <= snap_code;
        if (stop_strobe) begin
          done   <= 1'b1;
          t_stop <= stop_phase;
        end
      end
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CMAX) ovf_w <= 1'b1;
      if (stop_strobe) begin
        done   <= 1'b1;
        t_stop <= stop_phase;
      end
    end
  end
endmodule

// File: rtl/pixel_tdc_counter_props.sv
module pixel_tdc_counter_props #(
  parameter int CW = 6,
  parameter int RW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_count,
  input logic          frame_end,
  input logic [RW-1:0] result,
  input logic          result_valid,
  input logic          overflow
);
  assert_hold_between_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> ($stable(result) && $stable(result_valid) && $stable(overflow)));

  assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!result_valid && !overflow && result == '0));

  assert_count_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_end) && $past(mode_count)) |-> (result_valid && result[RW-1:CW] == '0));

  assert_wrap_not_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_end) && !$past(mode_count) && overflow) |-> (!result_valid && result == '0));

  assert_invalid_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_end) && !result_valid) |-> (result == '0));
endmodule

bind pixel_tdc_counter pixel_tdc_counter_props #(.CW(CW), .RW(RW)) u_props (
  .clk(clk), .rst_n(rst_n), .mode_count(mode_count), .frame_end(frame_end),
  .result(result), .result_valid(result_valid), .overflow(overflow)
);

// File: tb/pixel_tdc_counter_test.sv
`timescale 1ns/1ps
module pixel_tdc_counter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_count = 0, frame_start = 0, frame_end = 0;
  logic        start_pulse = 0, stop_strobe = 0;
  logic [15:0] snap = '0;
  logic [3:0]  stop_phase = '0;
  logic [9:0]  result;
  logic        result_valid, overflow;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pixel_tdc_counter uut (
    .clk(clk), .rst_n(rst_n), .mode_count(mode_count), .frame_start(frame_start),
    .frame_end(frame_end), .start_pulse(start_pulse), .stop_strobe(stop_strobe),
    .snap(snap), .stop_phase(stop_phase), .result(result),
    .result_valid(result_valid), .overflow(overflow)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    frame_start = 0; frame_end = 0; start_pulse = 0; stop_strobe = 0;
  endtask

  function automatic int code_of(input logic [15:0] s);
    for (int i = 0; i < 16; i++)
      if (!s[i] && s[(i + 15) % 16]) return i;
    return 0;
  endfunction

  function automatic int expect_time(input int coarse, input int sp, input int sc);
    int v = coarse * 16 + sp - sc;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic open_frame(input logic m);
    mode_count = m; frame_start = 1; step();
  endtask

  task automatic close_frame();
    frame_end = 1; step();
  endtask

  task automatic timed_frame(input string req, input logic [15:0] s, input int gap, input logic [3:0] sp);
    open_frame(0);
    start_pulse = 1; snap = s;
    if (gap == 0) begin stop_strobe = 1; stop_phase = sp; end
    step();
    if (gap > 0) begin
      for (int k = 0; k < gap - 1; k++) step();
      stop_strobe = 1; stop_phase = sp; step();
    end
    close_frame();
    if (gap > 63) begin
      chk({req, " overflow"}, overflow, 1);
      chk({req, " valid"}, result_valid, 0);
      chk({req, " result"}, result, 0);
    end else begin
      chk({req, " result"}, result, expect_time(gap, sp, code_of(s)));
      chk({req, " valid"}, result_valid, 1);
      chk({req, " overflow"}, overflow, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 result", result, 0);
    chk("R1 valid", result_valid, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_timing_basic();
    timed_frame("R4 basic", 16'h0007, 5, 4'd9);
    timed_frame("R4 borrow", 16'h0FFF, 2, 4'd1);
    timed_frame("R4 full scale", 16'h8000, 63, 4'd15);
  endtask

  task automatic t_decode();
    timed_frame("R3 bubble", 16'h00B3, 1, 4'd0);
    timed_frame("R3 wrapped run", 16'hF00F, 4, 4'd0);
    timed_frame("R3 rotated", 16'h0FF0, 3, 4'd2);
    timed_frame("R3 no transition", 16'hFFFF, 1, 4'd3);
  endtask

  task automatic t_same_cycle();
    timed_frame("R6 clamp", 16'h001F, 0, 4'd2);
    timed_frame("R6 positive", 16'h001F, 0, 4'd7);
  endtask

  task automatic t_first_only();
    open_frame(0);
    stop_strobe = 1; stop_phase = 4'd11; step();
    start_pulse = 1; snap = 16'h0007; step();
    step();
    start_pulse = 1; snap = 16'h03FF; step();
    step(); step();
    stop_strobe = 1; stop_phase = 4'd4; step();
    stop_strobe = 1; stop_phase = 4'd14; step();
    close_frame();
    chk("R5 later START/STOP ignored", result, expect_time(5, 4, 3));
    chk("R5 valid", result_valid, 1);
  endtask

  task automatic t_missing();
    open_frame(0);
    stop_strobe = 1; stop_phase = 4'd5; step();
    close_frame();
    chk("R8 no START valid", result_valid, 0);
    chk("R8 no START overflow", overflow, 0);
    chk("R8 no START result", result, 0);
    open_frame(0);
    start_pulse = 1; snap = 16'h0007; step();
    step(); step();
    close_frame();
    chk("R8 no STOP valid", result_valid, 0);
    chk("R8 no STOP result", result, 0);
  endtask

  task automatic t_wrap();
    timed_frame("R7 wrap", 16'h0007, 64, 4'd3);
  endtask

  task automatic t_counting();
    open_frame(1);
    for (int k = 0; k < 5; k++) begin start_pulse = 1; step(); step(); end
    close_frame();
    chk("R9 count", result, 5);
    chk("R9 valid", result_valid, 1);
    chk("R9 overflow", overflow, 0);
    open_frame(1);
    for (int k = 0; k < 70; k++) begin start_pulse = 1; step(); end
    close_frame();
    chk("R10 saturated", result, 63);
    chk("R10 overflow", overflow, 1);
    open_frame(1);
    for (int k = 0; k < 3; k++) begin start_pulse = 1; step(); end
    start_pulse = 1; frame_end = 1; step();
    chk("R11 pulse at frame end dropped", result, 3);
    chk("R11 overflow cleared", overflow, 0);
    start_pulse = 1; frame_start = 1; step();
    start_pulse = 1; step();
    close_frame();
    chk("R11 pulse at frame start dropped", result, 1);
  endtask

  task automatic t_hold();
    open_frame(1);
    for (int k = 0; k < 7; k++) begin start_pulse = 1; step(); end
    close_frame();
    chk("R2 count loaded", result, 7);
    for (int k = 0; k < 4; k++) begin start_pulse = 1; step(); end
    mode_count = 0;
    start_pulse = 1; snap = 16'h0007; step();
    stop_strobe = 1; stop_phase = 4'd9; step();
    chk("R2 result held", result, 7);
    chk("R2 valid held", result_valid, 1);
    close_frame();
    chk("R2 timing mode selected", result, expect_time(1, 9, 3));
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_timing_basic();
    t_decode();
    t_same_cycle();
    t_first_only();
    t_missing();
    t_wrap();
    t_counting();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule